// File: doc/BRIEF.md
# PCI Configuration Address/Data Port

This block connects a host I/O port bus to PCI configuration space through an indirect access pair: a 32-bit address port and a 4-byte data window. Software first writes a configuration address: an enable bit, a bus number, a device/function number and a register offset. It then reads or writes the data window with byte, word or dword accesses. The block steers each access onto the right byte lanes of the selected configuration dword. It answers reads of one built-in host-bridge function from its own identity bytes. Accesses to every other function go out on a single-cycle configuration request port. Functions that do not exist read as all ones.

Every host read that the block decodes is answered exactly one clock later on `io_rvalid`/`io_rdata`, with the value in the low bits. Writes produce no response. The configuration target must answer within the cycle of the request: `cfg_rdata` and `cfg_present` are sampled at the same clock edge. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `pci_cfg_port`

## Requirements
- R1: After reset the latched configuration address is 0, `io_rvalid` is 0, `io_rdata` is 0 and no configuration request is raised.
- R2: The address port (ports ADDR_PORT to ADDR_PORT+3) latches all 32 bits of `io_wdata` only on a dword write (`io_size`=2) at offset 0. A dword read there returns the last value written. Any other size or offset is not stored, and a read of that kind returns all ones truncated to the access width.
- R3: The enable bit is bit 31 of the latched address. While it is 0, data-window reads return all ones truncated to the width, writes are dropped, and `cfg_req` stays 0.
- R4: A data-window access uses bus = latch bits 23:16, devfn = latch bits 15:8 (device in devfn 7:3, function in devfn 2:0), and dword offset = latch bits 7:2 with bits 1:0 forced to 0. Lane = `io_port`[1:0]. `cfg_be` holds one bit per byte of the access, starting at bit `lane`. `cfg_wdata` is `io_wdata` shifted up by 8*lane bits.
- R5: A forwarded read returns `cfg_rdata` shifted down by 8*lane bits, with all bits above the access width cleared.
- R6: A read of a function for which `cfg_present` is 0 returns all ones truncated to the access width (0xFF, 0xFFFF or 0xFFFFFFFF).
- R7: The host-bridge function (bus HB_BUS, devfn HB_DEVFN) is never forwarded. Its dword 0 reads {device ID, vendor ID}, little-endian. Byte 0x08 is the revision, 0x0A the sub-class, 0x0B the base class and 0x0E the header type. All other bytes read 0, and writes have no effect.
- R8: `io_size` encodes 0 = byte, 1 = word, 2 = dword and 3 = reserved. A data-window access whose bytes extend past the 4-byte window (lane + width > 4), or whose size is reserved, is rejected. A rejected read returns all ones truncated to the access width (32 bits for reserved), and a rejected write is dropped.
- R9: `io_rvalid` pulses for one cycle, exactly one cycle after each decoded read. It stays 0 after writes and after accesses to other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_valid | input | 1 | Host I/O access this cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Write data, low-aligned |
| io_rvalid | output | 1 | Read response valid |
| io_rdata | output | 32 | Read response data, low-aligned |
| cfg_req | output | 1 | Configuration request to a non-local function |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Target bus number |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 8 | Dword-aligned register offset |
| cfg_be | output | 4 | Byte lanes of the access |
| cfg_wdata | output | 32 | Lane-aligned write data |
| cfg_rdata | input | 32 | Dword read from the target |
| cfg_present | input | 1 | Addressed function exists |

## Verification
The hardest case to reach is a mismatch between the lane the host selects and the lane the target writes. That mismatch only shows up when a later read at a different width or offset returns the wrong bytes. The bench therefore runs a reference target that keeps a byte array for two functions on different buses, and a separate expected array of its own. Each write at a given width and lane is followed by readback at every legal width and lane of the same dword. The latched offset is given nonzero low bits so that a wrongly merged offset leads to a divergence.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  localparam logic [1:0] SZ_BYTE  = 2'd0;
  localparam logic [1:0] SZ_WORD  = 2'd1;
  localparam logic [1:0] SZ_DWORD = 2'd2;
  localparam logic [1:0] SZ_RSVD  = 2'd3;

  typedef struct packed {
    logic       enable;
    logic [6:0] spare;
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [7:0] offset;
  } cfg_addr_t;

  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE:  size_bytes = 3'd1;
      SZ_WORD:  size_bytes = 3'd2;
      SZ_DWORD: size_bytes = 3'd4;
      default:  size_bytes = 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_WORD: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgp_rst_sync.sv
module cfgp_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/cfgp_addr_latch.sv
module cfgp_addr_latch #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] value
);
  logic [W-1:0] val_q;
  logic [W-1:0] val_d;

  always_comb val_d = load_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val_q <= '0;
    else if (load) val_q <= val_d;
  end

  assign value = val_q;

  a_r2_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(val_q));
  a_r2_latch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (val_q == $past(load_val)));
endmodule

// File: rtl/cfgp_lane_steer.sv
module cfgp_lane_steer
  import pcicfg_pkg::*;
(
  input  logic [1:0]  lane,
  input  logic [1:0]  size,
  input  logic [31:0] host_wdata,
  input  logic [31:0] dw_rdata,
  output logic        fits,
  output logic [3:0]  lane_be,
  output logic [31:0] lane_wdata,
  output logic [31:0] host_rdata
);
  logic [2:0] nbytes;
  logic [2:0] span;
  logic [3:0] base_be;
  logic [4:0] shamt;

  always_comb begin
    nbytes = size_bytes(size);
    span   = {1'b0, lane} + nbytes;
    fits   = (nbytes != 3'd0) && (span <= 3'd4);
    case (size)
      SZ_BYTE:  base_be = 4'b0001;
      SZ_WORD:  base_be = 4'b0011;
      SZ_DWORD: base_be = 4'b1111;
      default:  base_be = 4'b0000;
    endcase
    shamt      = {lane, 3'b000};
    lane_be    = fits ? 4'(base_be << lane) : 4'b0000;
    lane_wdata = host_wdata << shamt;
    host_rdata = (dw_rdata >> shamt) & size_mask(size);
  end
endmodule

// File: rtl/cfgp_hb_ident.sv
module cfgp_hb_ident #(
  parameter logic [15:0] VENDOR_ID  = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID  = 16'h0C01,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [7:0]  CLASS_BASE = 8'h06,
  parameter logic [7:0]  CLASS_SUB  = 8'h00,
  parameter logic [7:0]  HDR_TYPE   = 8'h00
) (
  input  logic [5:0]  dw_index,
  output logic [31:0] dw_value
);
  always_comb begin
    case (dw_index)
      6'd0:    dw_value = {DEVICE_ID, VENDOR_ID};
      6'd2:    dw_value = {CLASS_BASE, CLASS_SUB, 8'h00, REVISION};
      6'd3:    dw_value = {8'h00, HDR_TYPE, 16'h0000};
      default: dw_value = 32'h0000_0000;
    endcase
  end
endmodule

// File: rtl/pci_cfg_port.sv
module pci_cfg_port
  import pcicfg_pkg::*;
#(
  parameter logic [15:0] ADDR_PORT  = 16'h0CF8,
  parameter logic [15:0] DATA_PORT  = 16'h0CFC,
  parameter logic [7:0]  HB_BUS     = 8'h00,
  parameter logic [7:0]  HB_DEVFN   = 8'h00,
  parameter logic [15:0] VENDOR_ID  = 16'h1AB5,
  parameter logic [15:0] DEVICE_ID  = 16'h0C01,
  parameter logic [7:0]  REVISION   = 8'h03,
  parameter logic [7:0]  CLASS_BASE = 8'h06,
  parameter logic [7:0]  CLASS_SUB  = 8'h00,
  parameter logic [7:0]  HDR_TYPE   = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [15:0] io_port,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic        io_rvalid,
  output logic [31:0] io_rdata,
  output logic        cfg_req,
  output logic        cfg_write,
  output logic [7:0]  cfg_bus,
  output logic [7:0]  cfg_devfn,
  output logic [7:0]  cfg_reg,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata,
  input  logic        cfg_present
);
  logic        rst_n_i;
  logic [31:0] latch_val;
  cfg_addr_t   caddr;
  logic        hit_addr, hit_data, addr_ok, latch_load;
  logic        is_hb, fits, data_go;
  logic [1:0]  lane;
  logic [31:0] hb_dw, sel_dw, aligned_rd, ones;
  logic [3:0]  lane_be;
  logic [31:0] lane_wdata;
  logic        rvalid_d, rvalid_q;
  logic [31:0] rdata_d, rdata_q;

  cfgp_rst_sync u_rst_sync (.clk(clk), .arst_n(rst_n), .srst_n(rst_n_i));

  // Port decode
  always_comb begin
    hit_addr   = io_valid && (io_port[15:2] == ADDR_PORT[15:2]);
    hit_data   = io_valid && (io_port[15:2] == DATA_PORT[15:2]);
    addr_ok    = (io_size == SZ_DWORD) && (io_port[1:0] == 2'b00);
    latch_load = hit_addr && io_write && addr_ok;
    lane       = io_port[1:0];
  end

  cfgp_addr_latch #(.W(32)) u_latch (
    .clk(clk), .rst_n(rst_n_i), .load(latch_load),
    .load_val(io_wdata), .value(latch_val)
  );

  assign caddr = cfg_addr_t'(latch_val);

  cfgp_hb_ident #(
    .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID), .REVISION(REVISION),
    .CLASS_BASE(CLASS_BASE), .CLASS_SUB(CLASS_SUB), .HDR_TYPE(HDR_TYPE)
  ) u_hb (
    .dw_index(caddr.offset[7:2]), .dw_value(hb_dw)
  );

  always_comb begin
    is_hb   = (caddr.bus == HB_BUS) && (caddr.devfn == HB_DEVFN);
    sel_dw  = is_hb ? hb_dw : cfg_rdata;
    ones    = size_mask(io_size);
  end

  cfgp_lane_steer u_steer (
    .lane(lane), .size(io_size), .host_wdata(io_wdata), .dw_rdata(sel_dw),
    .fits(fits), .lane_be(lane_be), .lane_wdata(lane_wdata),
    .host_rdata(aligned_rd)
  );

  // Configuration request port
  always_comb begin
    data_go   = hit_data && fits && caddr.enable;
    cfg_req   = data_go && !is_hb;
    cfg_write = io_write;
    cfg_bus   = caddr.bus;
    cfg_devfn = caddr.devfn;
    cfg_reg   = {caddr.offset[7:2], 2'b00};
    cfg_be    = lane_be;
    cfg_wdata = lane_wdata;
  end

  // Read response next state
  always_comb begin
    rvalid_d = 1'b0;
    rdata_d  = '0;
    if (hit_addr && !io_write) begin
      rvalid_d = 1'b1;
      rdata_d  = addr_ok ? latch_val : ones;
    end else if (hit_data && !io_write) begin
      rvalid_d = 1'b1;
      if (!data_go)         rdata_d = ones;
      else if (is_hb)       rdata_d = aligned_rd;
      else if (cfg_present) rdata_d = aligned_rd;
      else                  rdata_d = ones;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      if (rvalid_d) rdata_q <= rdata_d;
    end
  end

  assign io_rvalid = rvalid_q;
  assign io_rdata  = rdata_q;

  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rst_n_i)
    (io_valid && !io_write && (io_port[15:2] == ADDR_PORT[15:2] ||
     io_port[15:2] == DATA_PORT[15:2])) |=> io_rvalid);
  a_r9_write_silent: assert property (@(posedge clk) disable iff (!rst_n_i)
    (io_valid && io_write) |=> !io_rvalid);
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n_i)
    !latch_val[31] |-> !cfg_req);
  a_r7_bridge_local: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_req |-> !(cfg_bus == HB_BUS && cfg_devfn == HB_DEVFN));
  a_r8_reserved_size: assert property (@(posedge clk) disable iff (!rst_n_i)
    (io_size == SZ_RSVD) |-> !cfg_req);
  a_r4_lanes_present: assert property (@(posedge clk) disable iff (!rst_n_i)
    cfg_req |-> (cfg_be != 4'b0000));
endmodule

// File: tb/test_pci_cfg_port.sv
module test_pci_cfg_port;
  localparam logic [15:0] AP = 16'h0CF8;
  localparam logic [15:0] DP = 16'h0CFC;
  localparam logic [15:0] VID = 16'h1AB5;
  localparam logic [15:0] DID = 16'h0C01;
  localparam logic [7:0]  REV = 8'h03;
  localparam logic [7:0]  CBASE = 8'h06;
  localparam logic [7:0]  CSUB = 8'h00;
  localparam logic [7:0]  HDR = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_port = '0;
  logic [1:0] io_size = '0;
  logic [31:0] io_wdata = '0;
  logic io_rvalid;
  logic [31:0] io_rdata;
  logic cfg_req, cfg_write, cfg_present;
  logic [7:0] cfg_bus, cfg_devfn, cfg_reg;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;

  int n_chk = 0, n_fail = 0;
  logic [7:0] tgt_mem [2][256];
  logic [7:0] exp_mem [2][256];
  int tgt_idx;

  always #5 clk = ~clk;

  pci_cfg_port #(
    .ADDR_PORT(AP), .DATA_PORT(DP), .HB_BUS(8'h00), .HB_DEVFN(8'h00),
    .VENDOR_ID(VID), .DEVICE_ID(DID), .REVISION(REV),
    .CLASS_BASE(CBASE), .CLASS_SUB(CSUB), .HDR_TYPE(HDR)
  ) i_pci_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_port(io_port), .io_size(io_size), .io_wdata(io_wdata),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata), .cfg_req(cfg_req),
    .cfg_write(cfg_write), .cfg_bus(cfg_bus), .cfg_devfn(cfg_devfn),
    .cfg_reg(cfg_reg), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_present(cfg_present)
  );

  function automatic int dev_of(input logic [7:0] b, input logic [7:0] df);
    if (b == 8'h00 && df == 8'h08) return 0;
    if (b == 8'h01 && df == 8'h13) return 1;
    return -1;
  endfunction

  // Reference configuration target
  always_comb begin
    tgt_idx = dev_of(cfg_bus, cfg_devfn);
    cfg_present = (tgt_idx >= 0);
    for (int k = 0; k < 4; k++)
      cfg_rdata[8*k +: 8] = cfg_present ? tgt_mem[tgt_idx][8'(cfg_reg + 8'(k))] : 8'h00;
  end

  always @(posedge clk)
    if (cfg_req && cfg_write && tgt_idx >= 0)
      for (int k = 0; k < 4; k++)
        if (cfg_be[k]) tgt_mem[tgt_idx][8'(cfg_reg + 8'(k))] <= cfg_wdata[8*k +: 8];

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
  endfunction

  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    return (sz == 2'd0) ? 32'hFF : (sz == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [7:0] hb_byte(input logic [7:0] off);
    case (off)
      8'h00: return VID[7:0];
      8'h01: return VID[15:8];
      8'h02: return DID[7:0];
      8'h03: return DID[15:8];
      8'h08: return REV;
      8'h0A: return CSUB;
      8'h0B: return CBASE;
      8'h0E: return HDR;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [31:0] la, input logic [1:0] lane,
                                           input logic [1:0] sz);
    int nb, d;
    logic [31:0] r;
    logic [7:0] base;
    nb = nbytes(sz);
    r = 32'h0;
    base = {la[7:2], 2'b00} + 8'(lane);
    if (!la[31] || nb == 0 || int'(lane) + nb > 4) return ones_of(sz);
    if (la[23:16] == 8'h00 && la[15:8] == 8'h00) begin
      for (int k = 0; k < nb; k++) r[8*k +: 8] = hb_byte(base + 8'(k));
      return r;
    end
    d = dev_of(la[23:16], la[15:8]);
    if (d < 0) return ones_of(sz);
    for (int k = 0; k < nb; k++) r[8*k +: 8] = exp_mem[d][base + 8'(k)];
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic io_op(input logic wr, input logic [15:0] port, input logic [1:0] sz,
                       input logic [31:0] wd, output logic rv, output logic [31:0] rd,
                       output logic req_s, output logic [3:0] be_s, output logic [7:0] reg_s);
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_port = port; io_size = sz; io_wdata = wd;
    #1;
    req_s = cfg_req; be_s = cfg_be; reg_s = cfg_reg;
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
    rv = io_rvalid; rd = io_rdata;
  endtask

  logic [31:0] cur_la;

  task automatic set_addr(input logic [31:0] v);
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    io_op(1'b1, AP, 2'd2, v, rv, rd, rq, be, rg);
    cur_la = v;
  endtask

  function automatic logic [31:0] mk(input logic en, input logic [7:0] b,
                                     input logic [7:0] df, input logic [7:0] off);
    return {en, 7'h00, b, df, off};
  endfunction

  task automatic t_reset;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    chk("R1", "rvalid after reset", {31'h0, io_rvalid}, 32'h0);
    chk("R1", "rdata after reset", io_rdata, 32'h0);
    chk("R1", "cfg_req after reset", {31'h0, cfg_req}, 32'h0);
    io_op(1'b0, AP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R1", "latch after reset", rd, 32'h0);
    chk("R9", "rvalid on address read", {31'h0, rv}, 32'h1);
  endtask

  task automatic t_addr_port;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    set_addr(32'h8A5C_3E47);
    io_op(1'b0, AP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R2", "address readback", rd, 32'h8A5C_3E47);
    io_op(1'b1, AP, 2'd0, 32'h0000_0011, rv, rd, rq, be, rg);
    io_op(1'b1, AP + 16'd2, 2'd1, 32'h0000_2222, rv, rd, rq, be, rg);
    io_op(1'b0, AP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R2", "narrow writes ignored", rd, 32'h8A5C_3E47);
    io_op(1'b0, AP, 2'd1, 32'h0, rv, rd, rq, be, rg);
    chk("R2", "word read of address port", rd, 32'h0000_FFFF);
  endtask

  task automatic t_disabled;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    set_addr(mk(1'b0, 8'h00, 8'h08, 8'h10));
    io_op(1'b0, DP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R3", "disabled dword read", rd, 32'hFFFF_FFFF);
    chk("R3", "disabled read no request", {31'h0, rq}, 32'h0);
    io_op(1'b0, DP + 16'd1, 2'd0, 32'h0, rv, rd, rq, be, rg);
    chk("R3", "disabled byte read", rd, 32'h0000_00FF);
    io_op(1'b1, DP, 2'd2, 32'hDEAD_BEEF, rv, rd, rq, be, rg);
    chk("R3", "disabled write no request", {31'h0, rq}, 32'h0);
    set_addr(mk(1'b1, 8'h00, 8'h08, 8'h10));
    io_op(1'b0, DP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R3", "disabled write dropped", rd, exp_read(cur_la, 2'd0, 2'd2));
  endtask

  task automatic t_lanes;
    logic rv, rq; logic [31:0] rd, wd; logic [3:0] be; logic [7:0] rg, base;
    for (int d = 0; d < 2; d++) begin
      for (int sz = 0; sz < 3; sz++) begin
        for (int ln = 0; ln < 4; ln++) begin
          if (ln + nbytes(2'(sz)) <= 4) begin
            base = 8'h20 + 8'(4 * sz);
            set_addr(mk(1'b1, (d == 0) ? 8'h00 : 8'h01, (d == 0) ? 8'h08 : 8'h13,
                        base | 8'(ln ^ 1)));
            wd = 32'hC0 + 32'(d * 16 + sz * 4 + ln);
            wd = {wd[7:0] ^ 8'h5A, wd[7:0] ^ 8'hA5, wd[7:0] ^ 8'h3C, wd[7:0]};
            io_op(1'b1, DP + 16'(ln), 2'(sz), wd, rv, rd, rq, be, rg);
            chk("R4", "write byte enables", {28'h0, be},
                {28'h0, 4'(((1 << nbytes(2'(sz))) - 1) << ln)});
            chk("R4", "write dword offset", {24'h0, rg}, {24'h0, base});
            chk("R9", "no rvalid on write", {31'h0, rv}, 32'h0);
            for (int k = 0; k < nbytes(2'(sz)); k++)
              exp_mem[d][base + 8'(ln + k)] = wd[8*k +: 8];
            for (int rs = 0; rs < 3; rs++)
              for (int rl = 0; rl < 4; rl++)
                if (rl + nbytes(2'(rs)) <= 4) begin
                  io_op(1'b0, DP + 16'(rl), 2'(rs), 32'h0, rv, rd, rq, be, rg);
                  chk("R5", "lane readback", rd, exp_read(cur_la, 2'(rl), 2'(rs)));
                end
          end
        end
      end
    end
  endtask

  task automatic t_absent;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    set_addr(mk(1'b1, 8'h00, 8'h10, 8'h00));
    io_op(1'b0, DP, 2'd0, 32'h0, rv, rd, rq, be, rg);
    chk("R6", "absent byte", rd, 32'h0000_00FF);
    io_op(1'b0, DP + 16'd2, 2'd1, 32'h0, rv, rd, rq, be, rg);
    chk("R6", "absent word", rd, 32'h0000_FFFF);
    set_addr(mk(1'b1, 8'h01, 8'h08, 8'h04));
    io_op(1'b0, DP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R6", "absent dword other bus", rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_hostbridge;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    set_addr(mk(1'b1, 8'h00, 8'h00, 8'h00));
    io_op(1'b0, DP, 2'd1, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "vendor id", rd, {16'h0, VID});
    chk("R7", "bridge read not forwarded", {31'h0, rq}, 32'h0);
    io_op(1'b0, DP + 16'd2, 2'd1, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "device id", rd, {16'h0, DID});
    io_op(1'b1, DP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "bridge write not forwarded", {31'h0, rq}, 32'h0);
    io_op(1'b0, DP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "identity after write", rd, {DID, VID});
    set_addr(mk(1'b1, 8'h00, 8'h00, 8'h09));
    io_op(1'b0, DP + 16'd2, 2'd1, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "class word", rd, {16'h0, CBASE, CSUB});
    io_op(1'b0, DP, 2'd0, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "revision", rd, {24'h0, REV});
    set_addr(mk(1'b1, 8'h00, 8'h00, 8'h0C));
    io_op(1'b0, DP + 16'd2, 2'd0, 32'h0, rv, rd, rq, be, rg);
    chk("R7", "header type", rd, {24'h0, HDR});
  endtask

  task automatic t_window_fit;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    set_addr(mk(1'b1, 8'h00, 8'h08, 8'h30));
    io_op(1'b0, DP + 16'd3, 2'd1, 32'h0, rv, rd, rq, be, rg);
    chk("R8", "word at lane 3", rd, 32'h0000_FFFF);
    io_op(1'b0, DP + 16'd1, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R8", "dword at lane 1", rd, 32'hFFFF_FFFF);
    io_op(1'b0, DP, 2'd3, 32'h0, rv, rd, rq, be, rg);
    chk("R8", "reserved size", rd, 32'hFFFF_FFFF);
    io_op(1'b1, DP + 16'd3, 2'd1, 32'h0000_1234, rv, rd, rq, be, rg);
    chk("R8", "straddling write not forwarded", {31'h0, rq}, 32'h0);
    io_op(1'b1, DP + 16'd2, 2'd2, 32'h1234_5678, rv, rd, rq, be, rg);
    io_op(1'b0, DP, 2'd2, 32'h0, rv, rd, rq, be, rg);
    chk("R8", "rejected writes dropped", rd, exp_read(cur_la, 2'd0, 2'd2));
  endtask

  task automatic t_rvalid;
    logic rv, rq; logic [31:0] rd; logic [3:0] be; logic [7:0] rg;
    io_op(1'b0, 16'h0080, 2'd0, 32'h0, rv, rd, rq, be, rg);
    chk("R9", "other port no rvalid", {31'h0, rv}, 32'h0);
    io_op(1'b0, DP, 2'd0, 32'h0, rv, rd, rq, be, rg);
    chk("R9", "data read rvalid", {31'h0, rv}, 32'h1);
    @(negedge clk);
    chk("R9", "rvalid single pulse", {31'h0, io_rvalid}, 32'h0);
  endtask

  initial begin
    bit wd_hit;
    wd_hit = 1'b0;
    for (int d = 0; d < 2; d++)
      for (int i = 0; i < 256; i++) begin
        tgt_mem[d][i] = 8'(i * 7 + d * 3 + 1);
        exp_mem[d][i] = 8'(i * 7 + d * 3 + 1);
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      begin
        t_reset();
        t_addr_port();
        t_disabled();
        t_lanes();
        t_absent();
        t_hostbridge();
        t_window_fit();
        t_rvalid();
      end
      begin
        repeat (150000) @(posedge clk);
        wd_hit = 1'b1;
      end
    join_any
    disable fork;
    if (wd_hit) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule